// File: doc/BRIEF.md
# Stereo Audio Serial Output Formatter

This block turns a pair of parallel twos-complement samples (left and right) into a serial audio stream. It produces three outputs: a bit clock, a left/right word clock and one serial data line. All three are derived from one master clock that runs at 512 times the output sample rate.

Each frame is one sample period and lasts 512 master clocks. At the start of every frame the block captures a fresh sample pair and shifts it out MSB first in one of three alignments:

- Philips-style (I2S), where the data lags the word clock by one bit.
- Left-justified.
- Right-justified.

The word length can be set from 16 to 20 bits. The bit clock can run at 64 or 32 times the sample rate; the 32-times rate is the packed mode. A mute input zeroes the data line while the clocks keep running.

A falling edge on the sync input reloads the frame counter. Several instances that see the same sync edge therefore start their frames on the same master clock, exactly one frame length after that edge. Configuration comes in on static inputs and is expected to change only while the stream is idle or about to be realigned by sync.

Top module: `aud_ser_fmt`

## Requirements
- R1: While `rst` is high, `sdata`, `bclk` and `lrclk` are all 0.
- R2: `lrclk` has a period of 512 clock cycles and is high for exactly 256 of them. It only toggles in the cycle where `bclk` falls. In Philips mode it is low during the left half-frame; in both justified modes it is high during the left half-frame.
- R3: `bclk` has a period of 8 clocks (64 bits per frame), or 16 clocks when `cfg_packed` is 1 (32 bits per frame). It is low in the first half of each bit period. Apart from the effect of mute or configuration changes, `sdata` changes only in the cycle where `bclk` falls.
- R4: With `cfg_fmt` = 1 (left-justified), the sample MSB occupies bit slot 0 of its half-frame. The remaining sample bits follow, and every later slot carries 0.
- R5: With `cfg_fmt` = 0 or 3 (Philips), the data line carries the left-justified bit stream delayed by one bit period. The MSB therefore sits in slot 1 and the LSB of a full-width word spills into slot 0 of the following half-frame.
- R6: With `cfg_fmt` = 2 (right-justified), the sample LSB occupies the last slot of each half-frame and all leading slots carry 0.
- R7: The word length is W = 16 + `cfg_wlen`, limited to 20. The serialized word consists of bits 19 down to 20−W of the input sample.
- R8: When `cfg_packed` is 1, each half-frame has 16 bit slots and W is further limited to 16.
- R9: The sample pair is captured on the last clock of each frame and is first sent in the frame that follows. Input changes within a frame do not affect the data sent in that frame.
- R10: When `mute` is high at a rising clock edge, `sdata` is 0 after that edge. The clocks are unaffected.
- R11: If `sync_in` is first sampled low at clock edge E0 after having been sampled high, then `lrclk` takes its left-channel level at edge E0+512, having held its right-channel level just before. That frame carries valid data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 512 times the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Frame realign request; a falling edge reloads the frame counter; tie low when unused |
| cfg_fmt | input | 2 | Alignment: 0 Philips, 1 left-justified, 2 right-justified, 3 Philips |
| cfg_wlen | input | 3 | Word length minus 16; values above 4 select 20 |
| cfg_packed | input | 1 | 1 selects a 32-times bit clock, 0 a 64-times bit clock |
| mute | input | 1 | Forces the data line to zero |
| left_in | input | 20 | Left-channel sample, twos complement |
| right_in | input | 20 | Right-channel sample, twos complement |
| sdata | output | 1 | Serial data, MSB first, changing on the falling edge of `bclk` |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Left/right word clock |

## Verification
Two events can land on the same clock: the frame-start capture of a new sample pair, and the emission of the first bit of that frame. In Philips mode the first bit comes from a delay stage that still holds the previous frame's last bit. The bench provokes this overlap by changing the inputs in the middle of every frame and by releasing mute exactly at a frame boundary. The model decides, from the cycle each bit was produced in, whether the old or the new pair is expected. A sync edge also coincides with the counter reload, and it is judged by requiring the word-clock change to land on exactly the 512th edge after it, in every alignment and bit-clock rate.

// File: rtl/aud_ser_fmt_pkg.sv
package aud_ser_fmt_pkg;
  localparam logic [1:0] ALIGN_PHILIPS = 2'd0;
  localparam logic [1:0] ALIGN_LEFT    = 2'd1;
  localparam logic [1:0] ALIGN_RIGHT   = 2'd2;
  localparam logic [1:0] ALIGN_SPARE   = 2'd3;

  // Philips timing (and the spare code) use the one-bit delayed stream.
  function automatic logic align_delayed(input logic [1:0] a);
    return (a == ALIGN_PHILIPS) || (a == ALIGN_SPARE);
  endfunction
endpackage

// File: rtl/aud_fmt_timebase.sv
module aud_fmt_timebase #(
  parameter int FRAME_MCLK = 512,
  localparam int CNT_W = $clog2(FRAME_MCLK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_in,
  output logic [CNT_W-1:0] cnt,
  output logic             frame_end
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_MCLK - 1);
  // Outputs lag the counter by one register. Loading 1 on the edge that
  // sees the fall makes position 0 reach the pins a full frame later.
  localparam logic [CNT_W-1:0] SYNC_LOAD = CNT_W'(1);

  logic sync_q;
  logic sync_fall;

  assign sync_fall = sync_q & ~sync_in;
  assign frame_end = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 1'b0;
      cnt    <= '0;
    end else begin
      sync_q <= sync_in;
      if (sync_fall)
        cnt <= SYNC_LOAD;
      else if (frame_end)
        cnt <= '0;
      else
        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/aud_fmt_slotdec.sv
module aud_fmt_slotdec #(
  parameter int FRAME_MCLK = 512,
  parameter int FAST_BITS  = 64,
  localparam int CNT_W  = $clog2(FRAME_MCLK),
  localparam int LOG_L  = $clog2(FRAME_MCLK / FAST_BITS),
  localparam int SLOT_W = CNT_W - 1 - LOG_L
) (
  input  logic [CNT_W-1:0]  cnt,
  input  logic              packed_mode,
  output logic [SLOT_W-1:0] slot,
  output logic              half,
  output logic              bclk_lvl,
  output logic              period_end
);
  logic [SLOT_W-1:0] slot_fast;

  assign slot_fast = cnt[CNT_W-2:LOG_L];
  assign half      = cnt[CNT_W-1];

  generate
    if (LOG_L > 0) begin : g_div
      always_comb begin
        if (packed_mode) begin
          slot       = slot_fast >> 1;
          bclk_lvl   = cnt[LOG_L];
          period_end = &cnt[LOG_L:0];
        end else begin
          slot       = slot_fast;
          bclk_lvl   = cnt[LOG_L-1];
          period_end = &cnt[LOG_L-1:0];
        end
      end
    end else begin : g_nodiv
      assign slot       = slot_fast;
      assign bclk_lvl   = packed_mode;
      assign period_end = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/aud_fmt_wordsel.sv
module aud_fmt_wordsel
  import aud_ser_fmt_pkg::*;
#(
  parameter int SAMPLE_W = 20,
  parameter int MIN_W    = 16,
  parameter int WLEN_W   = 3,
  parameter int SLOT_W   = 5,
  localparam int IW = SLOT_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_end,
  input  logic                period_end,
  input  logic [SLOT_W-1:0]   slot,
  input  logic                half,
  input  logic [1:0]          align,
  input  logic [WLEN_W-1:0]   wlen,
  input  logic                packed_mode,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  output logic                ser_bit
);
  localparam logic [IW-1:0] HS_FAST = IW'(1 << SLOT_W);
  localparam logic [IW-1:0] HS_SLOW = IW'(1 << (SLOT_W - 1));
  localparam logic [IW-1:0] W_MAX   = IW'(SAMPLE_W);
  localparam logic [IW-1:0] W_MIN   = IW'(MIN_W);

  logic [SAMPLE_W-1:0] hold_l, hold_r, smp, shifted;
  logic [IW-1:0]       wl_raw, wl_cap, hs, wl, off, slot_w, j;
  logic                in_word, lj_bit, dly;

  always_comb begin
    wl_raw  = W_MIN + IW'(wlen);
    wl_cap  = (wl_raw > W_MAX) ? W_MAX : wl_raw;
    hs      = packed_mode ? HS_SLOW : HS_FAST;
    wl      = (wl_cap > hs) ? hs : wl_cap;
    off     = (align == ALIGN_RIGHT) ? (hs - wl) : '0;
    slot_w  = IW'(slot);
    j       = slot_w - off;
    in_word = (slot_w >= off) && (j < wl);
    smp     = half ? hold_r : hold_l;
    shifted = smp << j;
    lj_bit  = in_word & shifted[SAMPLE_W-1];
    ser_bit = align_delayed(align) ? dly : lj_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_l <= '0;
      hold_r <= '0;
      dly    <= 1'b0;
    end else begin
      if (frame_end) begin
        hold_l <= left_in;
        hold_r <= right_in;
      end
      if (period_end)
        dly <= lj_bit;
    end
  end
endmodule

// File: rtl/aud_ser_fmt.sv
module aud_ser_fmt
  import aud_ser_fmt_pkg::*;
#(
  parameter int FRAME_MCLK = 512,
  parameter int FAST_BITS  = 64,
  parameter int SAMPLE_W   = 20,
  parameter int MIN_W      = 16,
  parameter int WLEN_W     = 3,
  localparam int CNT_W  = $clog2(FRAME_MCLK),
  localparam int SLOT_W = CNT_W - 1 - $clog2(FRAME_MCLK / FAST_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sync_in,
  input  logic [1:0]          cfg_fmt,
  input  logic [WLEN_W-1:0]   cfg_wlen,
  input  logic                cfg_packed,
  input  logic                mute,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  output logic                sdata,
  output logic                bclk,
  output logic                lrclk
);
  logic [CNT_W-1:0]  cnt;
  logic              frame_end;
  logic [SLOT_W-1:0] slot;
  logic              half, bclk_lvl, period_end, ser_bit;

  aud_fmt_timebase #(.FRAME_MCLK(FRAME_MCLK)) u_time (
    .clk(clk), .rst(rst), .sync_in(sync_in),
    .cnt(cnt), .frame_end(frame_end)
  );

  aud_fmt_slotdec #(.FRAME_MCLK(FRAME_MCLK), .FAST_BITS(FAST_BITS)) u_slot (
    .cnt(cnt), .packed_mode(cfg_packed), .slot(slot), .half(half),
    .bclk_lvl(bclk_lvl), .period_end(period_end)
  );

  aud_fmt_wordsel #(
    .SAMPLE_W(SAMPLE_W), .MIN_W(MIN_W), .WLEN_W(WLEN_W), .SLOT_W(SLOT_W)
  ) u_word (
    .clk(clk), .rst(rst), .frame_end(frame_end), .period_end(period_end),
    .slot(slot), .half(half), .align(cfg_fmt), .wlen(cfg_wlen),
    .packed_mode(cfg_packed), .left_in(left_in), .right_in(right_in),
    .ser_bit(ser_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sdata <= 1'b0;
      bclk  <= 1'b0;
      lrclk <= 1'b0;
    end else begin
      sdata <= mute ? 1'b0 : ser_bit;
      bclk  <= bclk_lvl;
      lrclk <= align_delayed(cfg_fmt) ? half : ~half;
    end
  end
endmodule

// File: rtl/aud_ser_fmt_chk.sv
module aud_ser_fmt_chk #(
  parameter int FRAME_MCLK = 512,
  parameter int WLEN_W     = 3,
  localparam int KW = $clog2(FRAME_MCLK) + 2
) (
  input logic              clk,
  input logic              rst,
  input logic              sync_in,
  input logic [1:0]        cfg_fmt,
  input logic [WLEN_W-1:0] cfg_wlen,
  input logic              cfg_packed,
  input logic              mute,
  input logic              sdata,
  input logic              bclk,
  input logic              lrclk
);
  localparam int CW = WLEN_W + 4;
  localparam logic [KW-1:0] K_HIT = KW'(FRAME_MCLK + 1);

  logic          sync_q;
  logic [CW-1:0] cfg_now, cfg_q;
  logic [1:0]    quiet;
  logic [KW-1:0] k;
  logic          evt, fall, left_lvl;

  assign cfg_now  = {cfg_fmt, cfg_wlen, cfg_packed, mute};
  assign fall     = sync_q & ~sync_in;
  assign evt      = fall | (cfg_now != cfg_q);
  assign left_lvl = ~((cfg_fmt == 2'd0) || (cfg_fmt == 2'd3));

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 1'b0;
      cfg_q  <= cfg_now;
      quiet  <= 2'd0;
      k      <= '0;
    end else begin
      sync_q <= sync_in;
      cfg_q  <= cfg_now;
      if (evt) quiet <= 2'd0;
      else if (quiet != 2'd3) quiet <= quiet + 2'd1;
      if (fall) k <= KW'(1);
      else if (k != '0) k <= (k == K_HIT) ? '0 : k + 1'b1;
    end
  end

  // R3: data moves only with a falling bit clock once settled
  p_data_edge_r3: assert property (@(posedge clk) disable iff (rst)
    (quiet == 2'd3 && $changed(sdata)) |-> $fell(bclk));

  // R2: word clock toggles only with a falling bit clock
  p_lr_edge_r2: assert property (@(posedge clk) disable iff (rst)
    (quiet == 2'd3 && $changed(lrclk)) |-> $fell(bclk));

  // R10: mute zeroes data after the edge
  p_mute_zero_r10: assert property (@(posedge clk) disable iff (rst)
    mute |=> !sdata);

  // R11: word clock enters its left level one frame after the sync edge
  p_sync_realign_r11: assert property (@(posedge clk) disable iff (rst)
    (k == K_HIT) |-> (lrclk == left_lvl && $changed(lrclk)));
endmodule

bind aud_ser_fmt aud_ser_fmt_chk #(.FRAME_MCLK(FRAME_MCLK), .WLEN_W(WLEN_W)) u_chk (
  .clk(clk), .rst(rst), .sync_in(sync_in), .cfg_fmt(cfg_fmt),
  .cfg_wlen(cfg_wlen), .cfg_packed(cfg_packed), .mute(mute),
  .sdata(sdata), .bclk(bclk), .lrclk(lrclk)
);

// File: tb/aud_ser_fmt_tb.sv
`timescale 1ns/1ps
module aud_ser_fmt_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync_in = 1'b0;
  logic [1:0]  cfg_fmt = 2'd0;
  logic [2:0]  cfg_wlen = 3'd4;
  logic        cfg_packed = 1'b0;
  logic        mute = 1'b0;
  logic [19:0] left_in = '0;
  logic [19:0] right_in = '0;
  logic        sdata, bclk, lrclk;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  aud_ser_fmt u_dut (
    .clk(clk), .rst(rst), .sync_in(sync_in), .cfg_fmt(cfg_fmt),
    .cfg_wlen(cfg_wlen), .cfg_packed(cfg_packed), .mute(mute),
    .left_in(left_in), .right_in(right_in),
    .sdata(sdata), .bclk(bclk), .lrclk(lrclk)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Left-justified bit at a frame position, from the requirements R4 R6 R7 R8.
  function automatic bit model_bit(input int pos, input logic [19:0] sl,
                                   input logic [19:0] sr, input int al,
                                   input int wc, input bit pk);
    int per, hs, w, s, off, j;
    logic [19:0] smp;
    per = pk ? 16 : 8;
    hs  = pk ? 16 : 32;
    w   = 16 + wc;
    if (w > 20) w = 20;
    if (pk && w > 16) w = 16;
    s   = (pos % 256) / per;
    smp = (pos >= 256) ? sr : sl;
    off = (al == 2) ? hs - w : 0;
    j   = s - off;
    if (j < 0 || j >= w) return 1'b0;
    return smp[19 - j];
  endfunction

  task automatic run_case(input int al, input int wc, input bit pk,
                          input bit mu, input int idx);
    logic [19:0] a_l, a_r, b_l, b_r;
    int per, pos, msrc, e_b, e_l, e_d;
    int nb, nl, nd, ab, xb, al_a, al_x, ad, xd;
    bit dly;
    string tag_d;
    a_l = 20'hB3E59 ^ 20'(idx * 32'h1357);
    a_r = 20'h6C1A7 ^ 20'(idx * 32'h0F0F3);
    b_l = 20'h4F2D6 ^ 20'(idx * 32'h2468);
    b_r = 20'h9A0B3 ^ 20'(idx * 32'h0A5A5);
    per = pk ? 16 : 8;
    dly = (al == 0) || (al == 3);
    nb = 0; nl = 0; nd = 0; ab = 0; xb = 0; al_a = 0; al_x = 0; ad = 0; xd = 0;
    @(negedge clk);
    cfg_fmt = 2'(al); cfg_wlen = 3'(wc); cfg_packed = pk; mute = mu;
    left_in = a_l; right_in = a_r; sync_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    sync_in = 1'b0;
    for (int m = 0; m < 1536; m++) begin
      @(negedge clk);
      if (m >= 1) begin
        pos = m % 512;
        e_b = ((pos % per) >= per / 2) ? 1 : 0;
        e_l = dly ? ((pos >= 256) ? 1 : 0) : ((pos >= 256) ? 0 : 1);
        if (int'(bclk) != e_b) begin if (nb == 0) begin ab = bclk; xb = e_b; end nb++; end
        if (int'(lrclk) != e_l) begin if (nl == 0) begin al_a = lrclk; al_x = e_l; end nl++; end
        msrc = dly ? m - per : m;
        if (mu && m < 1024) begin
          if (sdata !== 1'b0) begin if (nd == 0) begin ad = sdata; xd = 0; end nd++; end
        end else if (msrc >= 512) begin
          e_d = model_bit(msrc % 512, (msrc < 1024) ? a_l : b_l,
                          (msrc < 1024) ? a_r : b_r, (al == 2) ? 2 : 1, wc, pk);
          if (int'(sdata) != e_d) begin if (nd == 0) begin ad = sdata; xd = e_d; end nd++; end
        end
      end
      if (m == 600) begin left_in = b_l; right_in = b_r; end
      if (m == 1023) mute = 1'b0;
    end
    if (mu) tag_d = "R10 sdata muted then released";
    else if (al == 1) tag_d = "R4 R7 R8 R9 sdata left-justified";
    else if (al == 2) tag_d = "R6 R7 R8 R9 sdata right-justified";
    else tag_d = "R5 R7 R8 R9 sdata philips";
    check(nb == 0, $sformatf("R3 bclk case %0d", idx), ab, xb);
    check(nl == 0, $sformatf("R2 R11 lrclk case %0d", idx), al_a, al_x);
    check(nd == 0, $sformatf("%s case %0d", tag_d, idx), ad, xd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int idx;
    int wl_list [6] = '{0, 1, 2, 3, 4, 7};
    repeat (4) @(negedge clk);
    // R1: outputs quiet under reset
    check(sdata == 1'b0, "R1 sdata in reset", sdata, 0);
    check(bclk == 1'b0, "R1 bclk in reset", bclk, 0);
    check(lrclk == 1'b0, "R1 lrclk in reset", lrclk, 0);
    rst = 1'b0;
    idx = 0;
    for (int al = 0; al < 3; al++)
      for (int w = 0; w < 6; w++)
        for (int pk = 0; pk < 2; pk++) begin
          run_case(al, wl_list[w], pk[0], 1'b0, idx);
          idx++;
        end
    run_case(1, 4, 1'b0, 1'b1, idx);
    run_case(0, 0, 1'b1, 1'b1, idx + 1);
    run_case(3, 4, 1'b0, 1'b0, idx + 2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule